// File: doc/BRIEF.md
# Nine-Bit Serial Receive Event Filter

This block sits behind the bit-level receiver of an asynchronous serial port that carries 9-bit characters. Each time the receiver finishes a frame it pulses a frame-done strobe together with the eight data bits, the ninth bit and the framing and parity error flags. From a mode field and a DMA-enable bit, the block decides three things. It decides whether the character is written to the receive holding register. It decides whether a DMA receive request is raised. It decides whether the CPU receive interrupt fires.

The ninth bit is usually an address or trailer marker. One mode drops every character whose ninth bit is clear. Another mode keeps every character. A third mode keeps every character and hands it to DMA, but still interrupts the CPU when a marked trailer arrives. When DMA is enabled, the ordinary receive interrupt gives way to the DMA request. Error conditions stay in sticky flags and drive a separate error interrupt, so the CPU can step in on abnormal events while DMA carries the normal traffic.

Top module: `rx9_event_filter`

## Requirements
- R1: Synchronous reset clears `buf_wr`, `dma_req`, `irq_rx`, `irq_err`, `err_flags` and `buf_data`/`buf_bit9`.
- R2: With `mode` = 2, a frame whose ninth bit is 0 produces no `buf_wr`, no `irq_rx` and no `dma_req`, and leaves `buf_data` unchanged. A frame whose ninth bit is 1 is accepted.
- R3: With `mode` = 3, every frame is accepted. `buf_data`/`buf_bit9` then hold that frame's data and ninth bit until the next accepted frame.
- R4: With `mode` = 7, every frame is accepted, and `irq_rx` fires only for a frame whose ninth bit is 1, whether `dma_en` is 0 or 1.
- R5: `dma_req` pulses for every accepted frame when `dma_en` = 1. In any mode other than 7, `dma_en` = 1 suppresses `irq_rx`. In any mode with `dma_en` = 0, `dma_req` stays 0.
- R6: Mode codes 0, 1, 4, 5 and 6 accept every frame, and `irq_rx` fires for every frame when `dma_en` = 0, regardless of the ninth bit.
- R7: `buf_wr`, `dma_req` and `irq_rx` are one-cycle pulses in the cycle right after the cycle in which `frame_done` is high. They are 0 in any cycle whose preceding cycle had no `frame_done`.
- R8: `err_flags[0]` (framing) and `err_flags[1]` (parity) are set by a frame flagged with that error, whether or not the frame is accepted. They stay set until cleared.
- R9: `err_flags[2]` (overrun) is set when a frame is accepted while the previous accepted frame has been neither read (`host_read`) nor taken (`dma_ack`). A read or take in the same cycle as `frame_done` frees the holding register in time.
- R10: Writing 1 to `err_clr[i]` clears `err_flags[i]`. When the same bit is set by an event in the same cycle, the set wins.
- R11: `irq_err` is 1 exactly when some bit of `err_flags` is 1, independent of `dma_en` and `mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_done | input | 1 | One-cycle pulse: a frame has been received |
| frame_data | input | DATA_W | Received data bits |
| frame_bit9 | input | 1 | Received ninth bit |
| err_frame | input | 1 | Framing error on this frame |
| err_parity | input | 1 | Parity error on this frame |
| mode | input | 3 | Receive mode code |
| dma_en | input | 1 | Route accepted characters to DMA |
| host_read | input | 1 | CPU has read the holding register |
| dma_ack | input | 1 | DMA has taken the holding register |
| err_clr | input | 3 | Write-one-to-clear strobes for `err_flags` |
| buf_wr | output | 1 | Holding register written this cycle |
| buf_data | output | DATA_W | Holding register data |
| buf_bit9 | output | 1 | Holding register ninth bit |
| dma_req | output | 1 | DMA receive request pulse |
| irq_rx | output | 1 | CPU receive interrupt pulse |
| irq_err | output | 1 | Error interrupt level |
| err_flags | output | 3 | Sticky flags: [0] framing, [1] parity, [2] overrun |

## Verification
The hardest situations to reach are the collisions in one cycle. In one, a new frame arrives in the same cycle as the read that frees the holding register. In the other, an error is set in the same cycle as the strobe that clears it. Random stimulus seldom lines these up, so directed cases drive `host_read`, `dma_ack` or `err_clr` in the same cycle as `frame_done`. The random phase also draws those strobes with a fair probability, so the overlap comes up often across all mode codes and DMA settings.

// File: rtl/rx9_pkg.sv
package rx9_pkg;
  localparam int MODE_W = 3;
  localparam int ERR_N  = 3;

  localparam logic [MODE_W-1:0] MODE_MARKED_ONLY = 3'd2;
  localparam logic [MODE_W-1:0] MODE_KEEP_ALL    = 3'd3;
  localparam logic [MODE_W-1:0] MODE_DMA_TRAILER = 3'd7;

  localparam int ERR_IDX_FRAME   = 0;
  localparam int ERR_IDX_PARITY  = 1;
  localparam int ERR_IDX_OVERRUN = 2;

  typedef struct packed {
    logic accept;
    logic cpu_irq;
    logic dma_irq;
  } rx9_route_t;
endpackage

// File: rtl/rx9_mode_decode.sv
module rx9_mode_decode
  import rx9_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic              bit9,
  input  logic              dma_en,
  output rx9_route_t        route
);
  logic keep;
  logic marker_gate;
  logic cpu_allowed;

  always_comb begin
    keep        = 1'b1;
    marker_gate = 1'b1;
    cpu_allowed = !dma_en;
    unique case (mode)
      MODE_MARKED_ONLY: begin
        keep        = bit9;
        marker_gate = 1'b1;
      end
      MODE_KEEP_ALL: begin
        keep        = 1'b1;
        marker_gate = 1'b1;
      end
      MODE_DMA_TRAILER: begin
        keep        = 1'b1;
        marker_gate = bit9;
        cpu_allowed = 1'b1;
      end
      default: begin
        keep        = 1'b1;
        marker_gate = 1'b1;
      end
    endcase
    route.accept  = keep;
    route.cpu_irq = keep & marker_gate & cpu_allowed;
    route.dma_irq = keep & dma_en;
  end
endmodule

// File: rtl/rx9_hold_tracker.sv
module rx9_hold_tracker (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic consume,
  output logic full,
  output logic overrun
);
  assign overrun = load & full & ~consume;

  always_ff @(posedge clk) begin
    if (rst) full <= 1'b0;
    else     full <= load | (full & ~consume);
  end
endmodule

// File: rtl/rx9_err_sticky.sv
module rx9_err_sticky #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)             flags[i] <= 1'b0;
      else if (set_vec[i]) flags[i] <= 1'b1;
      else if (clr_vec[i]) flags[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/rx9_event_filter.sv
module rx9_event_filter
  import rx9_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_done,
  input  logic [DATA_W-1:0] frame_data,
  input  logic              frame_bit9,
  input  logic              err_frame,
  input  logic              err_parity,
  input  logic [MODE_W-1:0] mode,
  input  logic              dma_en,
  input  logic              host_read,
  input  logic              dma_ack,
  input  logic [ERR_N-1:0]  err_clr,
  output logic              buf_wr,
  output logic [DATA_W-1:0] buf_data,
  output logic              buf_bit9,
  output logic              dma_req,
  output logic              irq_rx,
  output logic              irq_err,
  output logic [ERR_N-1:0]  err_flags
);
  rx9_route_t       route;
  logic             load;
  logic             hold_full;
  logic             ovr_evt;
  logic [ERR_N-1:0] err_set;

  rx9_mode_decode u_dec (
    .mode   (mode),
    .bit9   (frame_bit9),
    .dma_en (dma_en),
    .route  (route)
  );

  assign load = frame_done & route.accept;

  rx9_hold_tracker u_hold (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .consume (host_read | dma_ack),
    .full    (hold_full),
    .overrun (ovr_evt)
  );

  always_comb begin
    err_set                  = '0;
    err_set[ERR_IDX_FRAME]   = frame_done & err_frame;
    err_set[ERR_IDX_PARITY]  = frame_done & err_parity;
    err_set[ERR_IDX_OVERRUN] = ovr_evt;
  end

  rx9_err_sticky #(.N(ERR_N)) u_err (
    .clk     (clk),
    .rst     (rst),
    .set_vec (err_set),
    .clr_vec (err_clr),
    .flags   (err_flags)
  );

  assign irq_err = |err_flags;

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_wr   <= 1'b0;
      dma_req  <= 1'b0;
      irq_rx   <= 1'b0;
      buf_data <= '0;
      buf_bit9 <= 1'b0;
    end else begin
      buf_wr  <= load;
      dma_req <= frame_done & route.dma_irq;
      irq_rx  <= frame_done & route.cpu_irq;
      if (load) begin
        buf_data <= frame_data;
        buf_bit9 <= frame_bit9;
      end
    end
  end
endmodule

// File: rtl/rx9_event_filter_chk.sv
module rx9_event_filter_chk
  import rx9_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              frame_done,
  input logic              frame_bit9,
  input logic [MODE_W-1:0] mode,
  input logic              dma_en,
  input logic [ERR_N-1:0]  err_clr,
  input logic              err_frame,
  input logic              buf_wr,
  input logic              dma_req,
  input logic              irq_rx,
  input logic [ERR_N-1:0]  err_flags
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!buf_wr && !dma_req && !irq_rx && err_flags == '0));

  assert_idle_no_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    !frame_done |=> (!buf_wr && !dma_req && !irq_rx));

  assert_unmarked_dropped_R2: assert property (@(posedge clk) disable iff (rst)
    (frame_done && mode == MODE_MARKED_ONLY && !frame_bit9)
      |=> (!buf_wr && !dma_req && !irq_rx));

  assert_trailer_only_irq_R4: assert property (@(posedge clk) disable iff (rst)
    (frame_done && mode == MODE_DMA_TRAILER && !frame_bit9)
      |=> (buf_wr && !irq_rx));

  assert_dma_mutes_irq_R5: assert property (@(posedge clk) disable iff (rst)
    (frame_done && dma_en && mode != MODE_DMA_TRAILER) |=> !irq_rx);

  assert_clear_frame_flag_R10: assert property (@(posedge clk) disable iff (rst)
    (err_clr[ERR_IDX_FRAME] && !(frame_done && err_frame))
      |=> !err_flags[ERR_IDX_FRAME]);
endmodule

bind rx9_event_filter rx9_event_filter_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .frame_done (frame_done),
  .frame_bit9 (frame_bit9),
  .mode       (mode),
  .dma_en     (dma_en),
  .err_clr    (err_clr),
  .err_frame  (err_frame),
  .buf_wr     (buf_wr),
  .dma_req    (dma_req),
  .irq_rx     (irq_rx),
  .err_flags  (err_flags)
);

// File: tb/sim_rx9_event_filter.sv
`timescale 1ns/1ps
module sim_rx9_event_filter;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          frame_done = 1'b0;
  logic [DW-1:0] frame_data = '0;
  logic          frame_bit9 = 1'b0;
  logic          err_frame = 1'b0;
  logic          err_parity = 1'b0;
  logic [2:0]    mode = 3'd0;
  logic          dma_en = 1'b0;
  logic          host_read = 1'b0;
  logic          dma_ack = 1'b0;
  logic [2:0]    err_clr = '0;
  logic          buf_wr, buf_bit9, dma_req, irq_rx, irq_err;
  logic [DW-1:0] buf_data;
  logic [2:0]    err_flags;

  int n_chk = 0;
  int n_err = 0;

  logic          m_full  = 1'b0;
  logic [2:0]    m_flags = '0;
  logic [DW-1:0] m_data  = '0;
  logic          m_b9    = 1'b0;

  always #4 clk = ~clk;

  rx9_event_filter #(.DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .frame_done(frame_done), .frame_data(frame_data),
    .frame_bit9(frame_bit9), .err_frame(err_frame), .err_parity(err_parity),
    .mode(mode), .dma_en(dma_en), .host_read(host_read), .dma_ack(dma_ack),
    .err_clr(err_clr), .buf_wr(buf_wr), .buf_data(buf_data), .buf_bit9(buf_bit9),
    .dma_req(dma_req), .irq_rx(irq_rx), .irq_err(irq_err), .err_flags(err_flags)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic f_accept(input logic [2:0] md, input logic b9);
    return (md == 3'd2) ? b9 : 1'b1;
  endfunction

  function automatic logic f_irq(input logic [2:0] md, input logic b9, input logic de);
    logic acc;
    acc = f_accept(md, b9);
    if (md == 3'd7) return acc & b9;
    return acc & !de;
  endfunction

  // One cycle of stimulus, then checks in the following cycle.
  task automatic cyc(input logic fd, input logic [DW-1:0] d, input logic b9,
                     input logic fe, input logic pe, input logic [2:0] md,
                     input logic de, input logic rd, input logic ak,
                     input logic [2:0] clr, input string tag);
    logic e_acc, e_irq, e_dma, e_ovr;
    logic [2:0] set;
    @(negedge clk);
    frame_done = fd; frame_data = d; frame_bit9 = b9; err_frame = fe;
    err_parity = pe; mode = md; dma_en = de; host_read = rd; dma_ack = ak;
    err_clr = clr;
    e_acc = fd & f_accept(md, b9);
    e_irq = fd & f_irq(md, b9, de);
    e_dma = e_acc & de;
    e_ovr = e_acc & m_full & !(rd | ak);
    m_full = e_acc | (m_full & !(rd | ak));
    set = {e_ovr, fd & pe, fd & fe};
    m_flags = (m_flags & ~clr) | set;
    if (e_acc) begin m_data = d; m_b9 = b9; end
    @(negedge clk);
    frame_done = 1'b0; host_read = 1'b0; dma_ack = 1'b0; err_clr = '0;
    err_frame = 1'b0; err_parity = 1'b0;
    chk({tag, " buf_wr R7"}, 32'(buf_wr), 32'(e_acc));
    chk({tag, " irq_rx R4"}, 32'(irq_rx), 32'(e_irq));
    chk({tag, " dma_req R5"}, 32'(dma_req), 32'(e_dma));
    chk({tag, " buf_data R3"}, 32'({buf_bit9, buf_data}), 32'({m_b9, m_data}));
    chk({tag, " err_flags R8/R9/R10"}, 32'(err_flags), 32'(m_flags));
    chk({tag, " irq_err R11"}, 32'(irq_err), 32'(m_flags != 0));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd1357));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("reset R1", 32'({buf_wr, dma_req, irq_rx, irq_err, err_flags, buf_data}), 32'd0);

    // R2: mode 2 drops unmarked, keeps marked
    cyc(1, 8'hA5, 0, 0, 0, 3'd2, 0, 0, 0, 3'b000, "R2 unmarked");
    cyc(1, 8'h3C, 1, 0, 0, 3'd2, 0, 0, 0, 3'b000, "R2 marked");
    // idle cycle: no pulses (R7)
    cyc(0, 8'h00, 0, 0, 0, 3'd2, 0, 1, 0, 3'b000, "R7 idle");
    // R3: mode 3 keeps all
    cyc(1, 8'h11, 0, 0, 0, 3'd3, 0, 1, 0, 3'b000, "R3 b9=0");
    cyc(1, 8'h22, 1, 0, 0, 3'd3, 0, 1, 0, 3'b000, "R3 b9=1");
    // R4: mode 7 with and without dma
    cyc(1, 8'h33, 0, 0, 0, 3'd7, 1, 0, 1, 3'b000, "R4 dma data");
    cyc(1, 8'h44, 1, 0, 0, 3'd7, 1, 0, 1, 3'b000, "R4 dma trailer");
    cyc(1, 8'h55, 0, 0, 0, 3'd7, 0, 1, 0, 3'b000, "R4 nodma data");
    // R5: dma in mode 3 suppresses irq
    cyc(1, 8'h66, 1, 0, 0, 3'd3, 1, 0, 1, 3'b000, "R5 mode3 dma");
    // R6: other codes
    for (int m = 0; m < 8; m++)
      if (m != 2 && m != 3 && m != 7)
        cyc(1, 8'(m * 17), 1'(m & 1), 0, 0, 3'(m), 0, 1, 0, 3'b000, "R6 other");
    // R8: errors on dropped frame still latch
    cyc(1, 8'h77, 0, 1, 1, 3'd2, 0, 0, 0, 3'b000, "R8 dropped err");
    // R9: overrun then same-cycle read avoids it
    cyc(1, 8'h88, 0, 0, 0, 3'd3, 0, 0, 0, 3'b111, "R9 load");
    cyc(1, 8'h99, 0, 0, 0, 3'd3, 0, 0, 0, 3'b000, "R9 overrun");
    cyc(1, 8'hAA, 0, 0, 0, 3'd3, 0, 1, 0, 3'b100, "R9 read same cycle");
    // R10: set and clear collide, set wins
    cyc(1, 8'hBB, 0, 1, 0, 3'd3, 0, 1, 0, 3'b001, "R10 set wins");
    cyc(0, 8'h00, 0, 0, 0, 3'd3, 0, 0, 0, 3'b111, "R10 clear");

    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      cyc(r[0] | r[1], 8'($urandom), r[2], r[3] & r[4] & r[5], r[6] & r[7] & r[8],
          3'(r[11:9]), r[12], r[13] & r[14], r[15] & r[16],
          3'(r[19:17] & r[22:20]), "random");
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule